// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

A synchronous up counter built from 4-bit slices. A parameter sets how many slices are chained into one wide counter. Every state bit updates on the same rising clock edge. An active-low clear drives the whole count to zero at once, with no clock needed. An active-low load copies a flat data word into the count on the next edge.

Counting is controlled by two enables. The parallel enable goes to every slice. The trickle enable goes only to the lowest slice. Each later slice takes its trickle enable from the carry of the slice below it. A slice's carry is its trickle enable ANDed with its four state bits. The carry is combinational and does not wait for a clock edge. The final carry marks the all-ones count of the whole chain and can feed a further stage.

Clear acts asynchronously. Its release is passed through a short synchronizer, so no state changes on the edges that arrive while the release settles.

Top module: `casc_counter`

## Requirements
- R1: The count is held in slices of 4 bits, with the lowest slice at bits [3:0]. Every bit updates on the same rising clock edge.
- R2: While rst_ni is low, count_o is 0 and carry_o is 0 immediately, with no clock edge needed, whatever load_ni, data_i and the enables are doing.
- R3: When rst_ni is high and load_ni is low at a rising edge, count_o takes data_i on that edge and does not count, even with both enables high.
- R4: When rst_ni and load_ni are high and both en_par_i and en_trk_i are high at a rising edge, count_o increases by one (modulo 2^W) on that edge.
- R5: When load_ni is high and either en_par_i or en_trk_i is low at a rising edge, count_o keeps its value.
- R6: carry_o is high exactly when en_trk_i is high and count_o is all ones. It follows en_trk_i between clock edges.
- R7: Each slice wraps from 15 to 0. The full chain wraps from all ones to 0.
- R8: Slice k+1 counts only when every slice below it holds 15. Its trickle enable is the carry of slice k. The parallel enable is shared by all slices, so the chain behaves as one W-bit binary counter.
- R9: For the first SYNC_STAGES rising edges after rst_ni goes high, count_o does not change, even if a load or an increment is requested.
- R10: load_ni is sampled only at the rising edge. A low pulse on load_ni that ends before the edge has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous clear |
| load_ni | input | 1 | Active-low synchronous parallel load |
| en_par_i | input | 1 | Parallel count enable, shared by all slices |
| en_trk_i | input | 1 | Trickle count enable into slice 0 |
| data_i | input | 4*N_SLICES | Load data, lowest slice at [3:0] |
| count_o | output | 4*N_SLICES | Counter state |
| carry_o | output | 1 | Carry out of the top slice |

## Verification
On every cycle, the assertions check that each slice loads, increments or holds according to its load input and its two enables. They also check that a slice at 15 that counts wraps to 0, and that the count stays frozen while the clear release settles. Some behaviours can only be shown by the bench's scenarios. These are: the count forced to zero between edges, the carry following the trickle enable between edges, a load pulse that ends before the edge, and the way slices cooperate so the chain matches a single wide binary count across every value.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int SLICE_W = 4;
  typedef logic [SLICE_W-1:0] nib_t;
endpackage

// File: rtl/clr_sync.sv
module clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES:0]   sync_d;

  assign sync_d = {sync_q, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d[STAGES-1:0];
  end

  assign run_o = sync_q[STAGES-1];

  // once running, stays running until clear
  p_run_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_ni,
  input  logic en_par_i,
  input  logic en_trk_i,
  input  nib_t data_i,
  output nib_t q_o,
  output logic carry_o
);
  nib_t q_q;
  logic step;

  assign step = en_par_i & en_trk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (run_i) begin
      if (!load_ni)    q_q <= data_i;
      else if (step)   q_q <= q_q + nib_t'(1);
    end
  end

  assign q_o     = q_q;
  assign carry_o = en_trk_i & (&q_q);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !load_ni |=> q_q == $past(data_i));
  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && load_ni && en_par_i && en_trk_i |=> q_q == $past(q_q) + nib_t'(1));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && load_ni && !(en_par_i && en_trk_i) |=> $stable(q_q));
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && load_ni && en_par_i && carry_o |=> q_q == '0);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int N_SLICES    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int W          = N_SLICES * SLICE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic         en_par_i,
  input  logic         en_trk_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         carry_o
);
  logic            run;
  logic [N_SLICES:0] trk;

  clr_sync #(.STAGES(SYNC_STAGES)) i_clr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_o (run)
  );

  assign trk[0] = en_trk_i;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    cnt_slice i_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (run),
      .load_ni (load_ni),
      .en_par_i(en_par_i),
      .en_trk_i(trk[k]),
      .data_i  (data_i[k*SLICE_W +: SLICE_W]),
      .q_o     (count_o[k*SLICE_W +: SLICE_W]),
      .carry_o (trk[k+1])
    );
  end

  assign carry_o = trk[N_SLICES];

  p_settle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(count_o));
  p_chain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && load_ni && en_par_i && en_trk_i |=> count_o == $past(count_o) + W'(1));
endmodule

// File: tb/test_casc_counter.sv
module test_casc_counter;
  localparam int NS   = 2;
  localparam int SYNC = 2;
  localparam int W    = NS * 4;
  localparam int MOD  = 1 << W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_ni = 1'b1;
  logic         en_par_i = 1'b0;
  logic         en_trk_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] count_o;
  logic         carry_o;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0;

  always #2 clk_i = ~clk_i;

  casc_counter #(.N_SLICES(NS), .SYNC_STAGES(SYNC)) i_casc_counter (
    .clk_i, .rst_ni, .load_ni, .en_par_i, .en_trk_i, .data_i, .count_o, .carry_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one edge, then model update from inputs in effect at that edge
  task automatic step();
    logic ld, ep, et;
    logic [W-1:0] d;
    ld = load_ni; ep = en_par_i; et = en_trk_i; d = data_i;
    @(posedge clk_i);
    #1;
    if (!ld) ref_cnt = int'(d);
    else if (ep && et) ref_cnt = (ref_cnt + 1) % MOD;
  endtask

  function automatic int exp_carry(input int v, input logic et);
    return (et && v == MOD - 1) ? 1 : 0;
  endfunction

  task automatic load_val(input int v);
    load_ni = 1'b0; data_i = W'(v);
    step();
    load_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    finish_run();
  end

  initial begin
    // reset state
    repeat (2) @(posedge clk_i);
    #1;
    chk("R2 reset count", int'(count_o), 0);
    chk("R2 reset carry", int'(carry_o), 0);

    // release with load and count requested: frozen for SYNC edges
    load_ni = 1'b0; data_i = 8'h5A; en_par_i = 1'b1; en_trk_i = 1'b1;
    rst_ni = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(posedge clk_i); #1;
      chk("R9 frozen after release", int'(count_o), 0);
    end
    ref_cnt = 0;
    step();
    chk("R3 load after release", int'(count_o), ref_cnt);
    chk("R3 load value", int'(count_o), 'h5A);

    // full sweep with wrap, carry checked each cycle
    load_val(0);
    en_par_i = 1'b1; en_trk_i = 1'b1;
    for (int i = 0; i < MOD + 20; i++) begin
      step();
      chk("R4 R8 count", int'(count_o), ref_cnt);
      chk("R6 carry", int'(carry_o), exp_carry(ref_cnt, 1'b1));
    end

    // slice wrap 0x0F -> 0x10 and chain wrap FF -> 00
    load_val('h0F);
    step();
    chk("R7 slice wrap", int'(count_o), 'h10);
    load_val('hFF);
    step();
    chk("R7 chain wrap", int'(count_o), 0);

    // hold on each enable
    load_val('h3C);
    for (int e = 0; e < 3; e++) begin
      en_par_i = e[0]; en_trk_i = e[1];
      repeat (3) step();
      chk("R5 hold", int'(count_o), 'h3C);
    end
    load_val('hFF);
    en_par_i = 1'b1; en_trk_i = 1'b0;
    repeat (2) step();
    chk("R5 hold at all ones", int'(count_o), 'hFF);
    chk("R6 carry gated by trickle", int'(carry_o), 0);

    // carry follows trickle enable between edges, every value
    en_par_i = 1'b0;
    for (int v = 0; v < MOD; v++) begin
      load_val(v);
      en_trk_i = 1'b1; #0.5;
      chk("R6 carry trk high", int'(carry_o), exp_carry(v, 1'b1));
      en_trk_i = 1'b0; #0.5;
      chk("R6 carry trk low", int'(carry_o), exp_carry(v, 1'b0));
    end
    load_val('hFF);
    en_trk_i = 1'b1; #0.5;
    chk("R6 carry rises mid-cycle", int'(carry_o), 1);
    en_trk_i = 1'b0; #0.5;
    chk("R6 carry falls mid-cycle", int'(carry_o), 0);

    // upper slice counts only on lower slice at 15
    load_val('h0E);
    en_par_i = 1'b1; en_trk_i = 1'b1;
    step();
    chk("R8 upper waits", int'(count_o[7:4]), 0);
    step();
    chk("R8 upper steps", int'(count_o[7:4]), 1);
    chk("R1 both slices same edge", int'(count_o), 'h10);

    // load has priority over counting
    load_ni = 1'b0; data_i = 8'h77;
    step();
    load_ni = 1'b1;
    chk("R3 load beats count", int'(count_o), 'h77);

    // load pulse between edges is ignored
    en_par_i = 1'b0;
    load_ni = 1'b0; data_i = 8'hA5; #1;
    load_ni = 1'b1;
    step();
    chk("R10 short load pulse", int'(count_o), 'h77);

    // asynchronous clear mid-cycle, with load and enables active
    load_val('hFF);
    en_par_i = 1'b1; en_trk_i = 1'b1; load_ni = 1'b0;
    rst_ni = 1'b0; #0.5;
    chk("R2 async clear count", int'(count_o), 0);
    chk("R2 async clear carry", int'(carry_o), 0);
    @(posedge clk_i); #1;
    chk("R2 clear beats load", int'(count_o), 0);
    load_ni = 1'b1;
    rst_ni = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(posedge clk_i); #1;
      chk("R9 frozen before count", int'(count_o), 0);
    end
    ref_cnt = 0;
    step();
    chk("R4 first count after release", int'(count_o), ref_cnt);

    finish_run();
  end
endmodule